// File: doc/BRIEF.md
# FIFO-fed asynchronous serial transmitter

This block turns bytes held in an external first-word-fall-through FIFO into asynchronous serial frames on a single output line. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Whenever the FIFO reports data and the transmitter is idle, the block takes the head word, pops it with a one-cycle read strobe, and sends the frame. Back-to-back words leave exactly one idle cycle between frames.

Every flip-flop runs on the system clock. A first divider produces an oversampling tick once every `TICK_DIV` clocks. A second divider of the same design counts those ticks and raises a bit-period enable once every `OVERSAMPLE` ticks. The default values, 13 and 16, suit a 24 MHz clock at 115200 baud. The sequencer advances only on that enable. Both dividers are held at zero while the line is idle, so every frame starts at a fixed phase. A 2-bit state code is brought out for debugging.

Top module: `uart_fifo_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `tx` is 1, `state_code` is 2'b11 and `fifo_rd_en` is 0. This holds even when the FIFO is not empty.
- R2: In idle (`state_code` 2'b11), `tx` is 1. While `fifo_empty` is 1, the block stays idle and issues no read strobe.
- R3: When the block is idle, out of reset and sees `fifo_empty` low at a clock edge, it enters the start state (`state_code` 2'b10) at that edge. The start state drives `tx` low.
- R4: `fifo_rd_en` is high for exactly one clock per frame: the first clock of the start state. It is never high for two consecutive clocks.
- R5: The data state (`state_code` 2'b01) sends the captured byte on `tx`, bit 0 first and bit 7 last. Each bit is held for one bit period.
- R6: After bit 7, the stop state (`state_code` 2'b00) holds `tx` high for one full bit period, and then the block returns to idle.
- R7: Each start, data and stop bit lasts exactly `TICK_DIV*OVERSAMPLE` clocks. With the FIFO kept non-empty, successive start bits begin `10*TICK_DIV*OVERSAMPLE+1` clocks apart.
- R8: The byte sent is the FIFO head word present when the frame starts. Words go out in FIFO order, and every byte value is sent unchanged.
- R9: A reset during a frame returns the block to idle with `tx` high, and the aborted frame does not resume. The dividers are cleared, so the next start bit again lasts exactly `TICK_DIV*OVERSAMPLE` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the only clock in the block |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | High when the external FIFO holds no word |
| fifo_data | input | 8 | Head word of the external FIFO (first-word-fall-through) |
| tx | output | 1 | Serial line, high when idle |
| fifo_rd_en | output | 1 | One-cycle pop strobe to the FIFO |
| state_code | output | 2 | 11 idle, 10 start, 01 data, 00 stop |

## Verification
The bench builds the block with `TICK_DIV=3` and `OVERSAMPLE=4`, so one bit lasts 12 clocks and a frame lasts 121 clocks. That short frame makes it cheap to send all 256 byte values back to back, in a scrambled order, and to check the frame-to-frame spacing and the exact cycle of every state change. The small sizes also bring within reach a reset during the idle state with the FIFO full, an abort in the middle of a frame, and a measurement of the start bit right after the abort, which shows the dividers were cleared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int unsigned DATA_BITS = 8;
    localparam int unsigned IDX_W     = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    // Encoding is visible on the debug port.
    typedef enum logic [1:0] {
        ST_STOP  = 2'b00,
        ST_DATA  = 2'b01,
        ST_START = 2'b10,
        ST_IDLE  = 2'b11
    } tx_state_t;

    typedef struct packed {
        logic [DATA_BITS-1:0] bits;
        logic [IDX_W-1:0]     idx;
    } frame_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic step,
    output logic pulse
);
    localparam int unsigned W = uart_tx_pkg::cnt_width(RATIO);

    generate
        if (RATIO == 1) begin : g_pass
            assign pulse = run & step;
        end else begin : g_count
            localparam logic [W-1:0] LAST = W'(RATIO - 1);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (step) begin
                    if (cnt_q == LAST) cnt_q <= '0;
                    else               cnt_q <= cnt_q + 1'b1;
                end
            end

            assign pulse = run && step && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tx_sequencer.sv
module tx_sequencer
    import uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 fifo_empty,
    input  logic [DATA_BITS-1:0] fifo_data,
    output tx_state_t            state,
    output logic                 rd_en,
    output logic                 tx,
    output logic                 run
);
    tx_state_t state_q;
    frame_t    frame_q;
    logic      rd_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= '0;
            rd_en_q <= 1'b0;
        end else begin
            rd_en_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (!fifo_empty) begin
                        state_q      <= ST_START;
                        frame_q.bits <= fifo_data;
                        frame_q.idx  <= '0;
                        rd_en_q      <= 1'b1;
                    end
                end
                ST_START: begin
                    if (bit_en) state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (bit_en) begin
                        if (frame_q.idx == LAST_IDX) state_q <= ST_STOP;
                        else frame_q.idx <= frame_q.idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_en) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = frame_q.bits[frame_q.idx];
            default:  tx = 1'b1;
        endcase
    end

    assign state = state_q;
    assign rd_en = rd_en_q;
    assign run   = (state_q != ST_IDLE);
endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 13,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fifo_empty,
    input  logic [DATA_BITS-1:0] fifo_data,
    output logic                 tx,
    output logic                 fifo_rd_en,
    output logic [1:0]           state_code
);
    logic      tick;
    logic      bit_en;
    logic      run;
    tx_state_t state;

    pulse_divider #(.RATIO(TICK_DIV)) u_tick_div (
        .clk(clk), .rst(rst), .run(run), .step(1'b1), .pulse(tick)
    );

    pulse_divider #(.RATIO(OVERSAMPLE)) u_bit_div (
        .clk(clk), .rst(rst), .run(run), .step(tick), .pulse(bit_en)
    );

    tx_sequencer u_seq (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .state(state), .rd_en(fifo_rd_en), .tx(tx), .run(run)
    );

    assign state_code = state;
endmodule

// File: rtl/uart_fifo_tx_checker.sv
module uart_fifo_tx_checker #(
    parameter int unsigned TICK_DIV   = 13,
    parameter int unsigned OVERSAMPLE = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       fifo_empty,
    input logic       tx,
    input logic       fifo_rd_en,
    input logic [1:0] state_code,
    input logic       tick,
    input logic       bit_en
);
    localparam int unsigned GW = uart_tx_pkg::cnt_width(TICK_DIV);
    localparam int unsigned TW = uart_tx_pkg::cnt_width(OVERSAMPLE);
    localparam logic [GW-1:0] GAP_LAST  = GW'(TICK_DIV - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(OVERSAMPLE - 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || state_code == 2'b11 || tick) gap_q <= '0;
        else                                    gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || state_code == 2'b11 || bit_en) ticks_q <= '0;
        else if (tick)                            ticks_q <= ticks_q + 1'b1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (state_code == 2'b11 && tx && !fifo_rd_en));

    // R2
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b11) |-> tx);

    // R2
    no_start_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b11 && fifo_empty) |=> (state_code == 2'b11));

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b10) |-> !tx);

    // R4
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> !fifo_rd_en);

    // R4
    rd_start_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> (state_code == 2'b10 && $past(state_code) == 2'b11));

    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'b00) |-> tx);

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == GAP_LAST));

    // R7
    bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |-> (tick && ticks_q == TICK_LAST));
endmodule

bind uart_fifo_tx uart_fifo_tx_checker #(
    .TICK_DIV(TICK_DIV), .OVERSAMPLE(OVERSAMPLE)
) u_chk (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .tx(tx),
    .fifo_rd_en(fifo_rd_en), .state_code(state_code),
    .tick(tick), .bit_en(bit_en)
);

// File: tb/uart_fifo_tx_bench.sv
module uart_fifo_tx_bench;
    localparam int DIV = 3;
    localparam int OVS = 4;
    localparam int P   = DIV * OVS;
    localparam int H   = P / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       tx;
    logic       rd_en;
    logic [1:0] state_code;

    logic [7:0] mem [0:511];
    logic [8:0] wr_ptr = '0;
    logic [8:0] rd_ptr = '0;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    int  rd_high = 0;
    int  rd_double = 0;
    logic rd_prev = 1'b0;
    bit  done = 0;

    always #4 clk = ~clk;

    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_data  = mem[rd_ptr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en && (rd_ptr != wr_ptr)) rd_ptr <= rd_ptr + 1'b1;
    end

    always @(negedge clk) begin
        if (rd_en) rd_high <= rd_high + 1;
        if (rd_en && rd_prev) rd_double <= rd_double + 1;
        rd_prev <= rd_en;
    end

    uart_fifo_tx #(.TICK_DIV(DIV), .OVERSAMPLE(OVS)) u_uart_fifo_tx (
        .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .tx(tx), .fifo_rd_en(rd_en), .state_code(state_code)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] v);
        mem[wr_ptr] = v;
        wr_ptr = wr_ptr + 1'b1;
    endtask

    task automatic wait_fall(output int t, output bit ok);
        int guard = 0;
        @(negedge clk);
        while (tx !== 1'b0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        ok = (tx === 1'b0);
        t  = cyc;
        if (!ok) check(0, "R3 start bit never seen", 1, 0);
    endtask

    task automatic recv(output logic [7:0] got, output int t_fall);
        bit ok;
        got = '0;
        wait_fall(t_fall, ok);
        if (ok) begin
            check(state_code == 2'b10, "R3 start state code", state_code, 2);
            check(rd_en == 1'b1, "R4 strobe in first start cycle", rd_en, 1);
            wait_neg(H);
            check(tx == 1'b0, "R3 start bit low at mid", tx, 0);
            for (int i = 0; i < 8; i++) begin
                wait_neg(P);
                got[i] = tx;
                check(state_code == 2'b01, "R5 data state code", state_code, 1);
            end
            wait_neg(P);
            check(tx == 1'b1, "R6 stop bit high", tx, 1);
            check(state_code == 2'b00, "R6 stop state code", state_code, 0);
            wait_neg(H - 1);
            check(state_code == 2'b00, "R6 stop lasts full period", state_code, 0);
            wait_neg(1);
            check(state_code == 2'b11, "R6 idle after stop", state_code, 3);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int t_now;
        int t_prev;
        int frames = 0;
        int low_len;
        bit ok;

        // R1: reset state with empty FIFO
        wait_neg(4);
        check(tx == 1'b1, "R1 tx high in reset", tx, 1);
        check(state_code == 2'b11, "R1 idle code in reset", state_code, 3);
        check(rd_en == 1'b0, "R1 no strobe in reset", rd_en, 0);

        // R2: idle with empty FIFO
        rst = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tx !== 1'b1 || state_code !== 2'b11)
                check(0, "R2 idle holds while empty", state_code, 3);
        end
        check(rd_high == 0, "R2 no strobe while empty", rd_high, 0);

        // R1: reset holds with a non-empty FIFO
        rst = 1'b1;
        push(8'h5A);
        wait_neg(8);
        check(tx == 1'b1, "R1 tx high, FIFO non-empty", tx, 1);
        check(state_code == 2'b11, "R1 idle, FIFO non-empty", state_code, 3);
        check(rd_high == 0, "R1 no pop during reset", rd_high, 0);
        rst = 1'b0;
        recv(got, t_now);
        frames++;
        check(got == 8'h5A, "R8 first byte", got, 8'h5A);

        // R8 R5 R7: all byte values back to back, scrambled order
        for (int i = 0; i < 256; i++) push(8'((i * 37 + 11) & 255));
        for (int i = 0; i < 256; i++) begin
            recv(got, t_now);
            frames++;
            check(got == 8'((i * 37 + 11) & 255), "R8 byte order and R5 bit order",
                  got, (i * 37 + 11) & 255);
            if (i > 0)
                check(t_now - t_prev == 10 * P + 1, "R7 frame spacing",
                      t_now - t_prev, 10 * P + 1);
            t_prev = t_now;
        end
        wait_neg(3);
        check(fifo_empty == 1'b1, "R8 every word popped", fifo_empty, 1);

        // R9: abort mid-frame
        push(8'h00);
        wait_fall(t_now, ok);
        frames++;
        wait_neg(30);
        rst = 1'b1;
        wait_neg(1);
        check(state_code == 2'b11, "R9 reset aborts to idle", state_code, 3);
        check(tx == 1'b1, "R9 tx high after abort", tx, 1);
        rst = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tx !== 1'b1 || state_code !== 2'b11)
                check(0, "R9 aborted frame stays dead", state_code, 3);
        end

        // R9 R7: start bit length after abort
        push(8'hFF);
        wait_fall(t_now, ok);
        frames++;
        low_len = 1;
        while (tx === 1'b0 && low_len < 100) begin
            @(negedge clk);
            if (tx === 1'b0) low_len++;
        end
        check(low_len == P, "R9 R7 start bit length", low_len, P);
        wait_neg(10 * P);
        check(state_code == 2'b11, "R6 back to idle", state_code, 3);

        // R4: strobe count and width
        check(rd_high == frames, "R4 one strobe per frame", rd_high, frames);
        check(rd_double == 0, "R4 strobe never two cycles", rd_double, 0);

        done = 1;
        report();
        $finish;
    end
endmodule